// File: doc/BRIEF.md
# Control Transfer Target Alignment Unit

This unit lives in the execute stage of a small RISC-V style core and resolves every control transfer: direct jumps, register-indirect jumps and conditional branches. From the current program counter, the immediate, the source register value and the class of the operation, it forms the destination address. It then decides whether the destination breaks the instruction alignment rule. A good destination produces a one-cycle redirect and, for the two jump kinds, a return-address write. A bad destination raises an instruction-address-misaligned trap instead. The trap carries the faulting address and leaves no architectural trace: no redirect, no return-address write, and therefore no fetch is ever issued to the bad address.

The alignment rule depends on whether compressed (16-bit) instructions are enabled. With them disabled, a destination whose bit 1 is set is illegal. With them enabled, only bit 0 matters, and because bit 0 is always cleared no destination can fault. The unit also conditions data written to the exception-return and debug-return address registers so that a later return through either of them can never fault on alignment.

Results are held in a three-state machine. S_IDLE means no result is being presented. S_REDIR presents a legal redirect. S_TRAP presents a misaligned-target trap. Each cycle the machine moves to S_REDIR when the sampled operation is a jump, or a taken branch, with a legal destination. It moves to S_TRAP when such an operation has an illegal destination. It moves to S_IDLE for no valid operation, a not-taken branch, or the no-operation class. The same rule applies from every state, so each result lasts one cycle unless another operation follows at once.

Top module: `xfer_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, redirect_o, link_we_o, trap_o and both bits of csr_we_o are low.
- R2: The destination is pc_i + imm_i for op_class_i 1 (direct jump) and 3 (branch), and rs1_i + imm_i for op_class_i 2 (indirect jump); bit 0 of the destination is always cleared. A legal destination appears on next_pc_o with redirect_o high in the cycle after the operation is sampled.
- R3: For an indirect jump, bit 0 of rs1_i + imm_i is forced to zero before the alignment decision, whatever its value.
- R4: With cmp_en_i low, a destination with bit 1 set raises trap_o for one cycle, with the destination on trap_addr_o, while redirect_o and link_we_o stay low.
- R5: A legal direct or indirect jump writes the return address: link_we_o high with link_data_o = pc_i + 4, or pc_i + 2 when is_cmp_i is high.
- R6: With cmp_en_i high, no destination raises trap_o.
- R7: A taken branch (br_taken_i high) redirects or traps but never writes the return address; a not-taken branch, or op_class_i 0, produces neither redirect nor trap, even if the destination would be misaligned.
- R8: Return-address register writes pass csr_we_i (bit 0 exception return, bit 1 debug return) to csr_we_o one cycle later with csr_data_o equal to csr_data_i with bit 0 cleared, and bit 1 also cleared when cmp_en_i is low.
- R9: redirect_o and trap_o are never high together, and both are low in the cycle after a cycle with op_valid_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | A control-transfer operation is present this cycle |
| op_class_i | input | 2 | 0 none, 1 direct jump, 2 indirect jump, 3 conditional branch |
| br_taken_i | input | 1 | Branch condition result |
| cmp_en_i | input | 1 | Compressed instructions enabled |
| is_cmp_i | input | 1 | Current instruction is 16-bit |
| pc_i | input | XLEN | Address of the current instruction |
| imm_i | input | XLEN | Sign-extended offset |
| rs1_i | input | XLEN | Base register value for indirect jumps |
| csr_we_i | input | 2 | Write strobes: bit 0 exception return, bit 1 debug return |
| csr_data_i | input | XLEN | Raw return-address write data |
| redirect_o | output | 1 | One-cycle strobe: fetch from next_pc_o |
| next_pc_o | output | XLEN | Redirect destination |
| link_we_o | output | 1 | Return-address register write enable |
| link_data_o | output | XLEN | Return address |
| trap_o | output | 1 | One-cycle misaligned-target trap strobe |
| trap_addr_o | output | XLEN | Faulting destination for the trap-value register |
| csr_we_o | output | 2 | Delayed write strobes |
| csr_data_o | output | XLEN | Masked return-address write data |

## Verification
Every result is due exactly one clock edge after its operation is sampled. The redirect, trap and return-address outputs come from the state register and data registers loaded at that edge, and the masked register write follows the same one-register path. The driver applies each operation at a falling edge and queues its expected outcome. The monitor pops one item per rising edge and compares it a nanosecond later, so a result is always checked in the cycle it is due and never one early or late. Idle cycles push idle expectations, so a strobe that lasts longer than one cycle is caught.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_JAL  = 2'd1,
        OP_JALR = 2'd2,
        OP_BR   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REDIR = 2'd1,
        S_TRAP  = 2'd2
    } st_e;
endpackage

// File: rtl/xfer_target_calc.sv
module xfer_target_calc
    import xfer_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] rs1,
    input  logic            cmp_en,
    output logic [XLEN-1:0] target,
    output logic            misaligned
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    always_comb begin
        base       = (op == OP_JALR) ? rs1 : pc;
        sum        = base + imm;
        // bit 0 cleared before the alignment decision
        target     = {sum[XLEN-1:1], 1'b0};
        misaligned = !cmp_en && target[1];
    end
endmodule

// File: rtl/xfer_ret_mask.sv
module xfer_ret_mask #(
    parameter int XLEN = 32
) (
    input  logic            cmp_en,
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b == 0) begin : g_lsb
            assign dout[b] = 1'b0;
        end else if (b == 1) begin : g_half
            assign dout[b] = din[b] & cmp_en;
        end else begin : g_pass
            assign dout[b] = din[b];
        end
    end
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
    import xfer_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NRET  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid_i,
    input  logic [1:0]      op_class_i,
    input  logic            br_taken_i,
    input  logic            cmp_en_i,
    input  logic            is_cmp_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [NRET-1:0] csr_we_i,
    input  logic [XLEN-1:0] csr_data_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            trap_o,
    output logic [XLEN-1:0] trap_addr_o,
    output logic [NRET-1:0] csr_we_o,
    output logic [XLEN-1:0] csr_data_o
);
    localparam logic [XLEN-1:0] STEP_FULL = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);

    op_e             op;
    st_e             state_q, state_d;
    logic [XLEN-1:0] target;
    logic            misaligned;
    logic [XLEN-1:0] masked;
    logic            is_jump;
    logic [XLEN-1:0] dest_q;
    logic [XLEN-1:0] link_q;
    logic            link_pend_q;
    logic [NRET-1:0] csr_we_q;
    logic [XLEN-1:0] csr_data_q;

    assign op      = op_e'(op_class_i);
    assign is_jump = (op == OP_JAL) || (op == OP_JALR);

    xfer_target_calc #(.XLEN(XLEN)) u_tgt (
        .op         (op),
        .pc         (pc_i),
        .imm        (imm_i),
        .rs1        (rs1_i),
        .cmp_en     (cmp_en_i),
        .target     (target),
        .misaligned (misaligned)
    );

    xfer_ret_mask #(.XLEN(XLEN)) u_mask (
        .cmp_en (cmp_en_i),
        .din    (csr_data_i),
        .dout   (masked)
    );

    // next-state decision
    always_comb begin
        state_d = S_IDLE;
        if (op_valid_i) begin
            unique case (op)
                OP_JAL, OP_JALR: state_d = misaligned ? S_TRAP : S_REDIR;
                OP_BR:           state_d = !br_taken_i ? S_IDLE :
                                           (misaligned ? S_TRAP : S_REDIR);
                OP_NONE:         state_d = S_IDLE;
                default:         state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q      <= '0;
            link_q      <= '0;
            link_pend_q <= 1'b0;
            csr_we_q    <= '0;
            csr_data_q  <= '0;
        end else begin
            dest_q      <= target;
            link_q      <= pc_i + (is_cmp_i ? STEP_HALF : STEP_FULL);
            link_pend_q <= op_valid_i && is_jump;
            csr_we_q    <= csr_we_i;
            csr_data_q  <= masked;
        end
    end

    // outputs from state
    always_comb begin
        redirect_o  = 1'b0;
        trap_o      = 1'b0;
        link_we_o   = 1'b0;
        next_pc_o   = dest_q;
        trap_addr_o = dest_q;
        link_data_o = link_q;
        unique case (state_q)
            S_IDLE:  ;
            S_REDIR: begin
                redirect_o = 1'b1;
                link_we_o  = link_pend_q;
            end
            S_TRAP:  trap_o = 1'b1;
            default: ;
        endcase
        csr_we_o   = csr_we_q;
        csr_data_o = csr_data_q;
    end
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk #(
    parameter int XLEN = 32,
    parameter int NRET = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid_i,
    input logic [1:0]      op_class_i,
    input logic            br_taken_i,
    input logic            cmp_en_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            link_we_o,
    input logic            trap_o,
    input logic [NRET-1:0] csr_we_o,
    input logic [XLEN-1:0] csr_data_o
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_o && trap_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !redirect_o && !trap_o); // R9
    AST_TRAP_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !link_we_o && !redirect_o); // R4
    AST_DEST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !next_pc_o[0]); // R3
    AST_CMP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && cmp_en_i |=> !trap_o); // R6
    AST_BR_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_class_i == 2'd3 |=> !link_we_o); // R7
    AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_class_i == 2'd3 && !br_taken_i |=> !redirect_o && !trap_o); // R7
    AST_RET_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (|csr_we_o) |-> !csr_data_o[0]); // R8
endmodule

bind xfer_unit xfer_unit_chk #(.XLEN(XLEN), .NRET(NRET)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .op_class_i (op_class_i),
    .br_taken_i (br_taken_i),
    .cmp_en_i   (cmp_en_i),
    .redirect_o (redirect_o),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .trap_o     (trap_o),
    .csr_we_o   (csr_we_o),
    .csr_data_o (csr_data_o)
);

// File: tb/sim_xfer_unit.sv
module sim_xfer_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid_i = 1'b0;
    logic [1:0]      op_class_i = 2'd0;
    logic            br_taken_i = 1'b0;
    logic            cmp_en_i = 1'b0;
    logic            is_cmp_i = 1'b0;
    logic [XLEN-1:0] pc_i = '0;
    logic [XLEN-1:0] imm_i = '0;
    logic [XLEN-1:0] rs1_i = '0;
    logic [1:0]      csr_we_i = '0;
    logic [XLEN-1:0] csr_data_i = '0;
    logic            redirect_o;
    logic [XLEN-1:0] next_pc_o;
    logic            link_we_o;
    logic [XLEN-1:0] link_data_o;
    logic            trap_o;
    logic [XLEN-1:0] trap_addr_o;
    logic [1:0]      csr_we_o;
    logic [XLEN-1:0] csr_data_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string           req;
        logic            redir;
        logic [XLEN-1:0] npc;
        logic            lwe;
        logic [XLEN-1:0] ldata;
        logic            trap;
        logic [XLEN-1:0] taddr;
        logic [1:0]      cwe;
        logic [XLEN-1:0] cdata;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    xfer_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_class_i(op_class_i),
        .br_taken_i(br_taken_i), .cmp_en_i(cmp_en_i), .is_cmp_i(is_cmp_i),
        .pc_i(pc_i), .imm_i(imm_i), .rs1_i(rs1_i), .csr_we_i(csr_we_i),
        .csr_data_i(csr_data_i), .redirect_o(redirect_o), .next_pc_o(next_pc_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o), .trap_o(trap_o),
        .trap_addr_o(trap_addr_o), .csr_we_o(csr_we_o), .csr_data_o(csr_data_o)
    );

    task automatic cmp1(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: one call = one cycle of stimulus and one expected item
    task automatic issue(string req, bit v, logic [1:0] cls, bit taken, bit cen, bit cmp,
                         logic [XLEN-1:0] pc, logic [XLEN-1:0] imm, logic [XLEN-1:0] rs1,
                         logic [1:0] cwe, logic [XLEN-1:0] cdata);
        exp_t e;
        logic [XLEN-1:0] dest;
        bit bad, act;
        @(negedge clk);
        op_valid_i = v; op_class_i = cls; br_taken_i = taken; cmp_en_i = cen;
        is_cmp_i = cmp; pc_i = pc; imm_i = imm; rs1_i = rs1;
        csr_we_i = cwe; csr_data_i = cdata;
        dest = ((cls == 2'd2) ? rs1 : pc) + imm;
        dest[0] = 1'b0;
        bad = !cen && dest[1];
        act = v && (cls == 2'd1 || cls == 2'd2 || (cls == 2'd3 && taken));
        e.req   = req;
        e.redir = act && !bad;
        e.trap  = act && bad;
        e.npc   = dest;
        e.taddr = dest;
        e.lwe   = e.redir && (cls != 2'd3);
        e.ldata = pc + (cmp ? 2 : 4);
        e.cwe   = cwe;
        e.cdata = cdata & ~(cen ? 32'h1 : 32'h3);
        sb.push_back(e);
    endtask

    task automatic idle(string req);
        issue(req, 0, 2'd0, 0, 0, 0, '0, '0, '0, 2'b00, '0);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp1(e.req, "redirect", XLEN'(redirect_o), XLEN'(e.redir));
                cmp1(e.req, "trap", XLEN'(trap_o), XLEN'(e.trap));
                cmp1(e.req, "link_we", XLEN'(link_we_o), XLEN'(e.lwe));
                cmp1(e.req, "csr_we", XLEN'(csr_we_o), XLEN'(e.cwe));
                if (e.redir) cmp1(e.req, "next_pc", next_pc_o, e.npc);
                if (e.trap)  cmp1(e.req, "trap_addr", trap_addr_o, e.taddr);
                if (e.lwe)   cmp1(e.req, "link_data", link_data_o, e.ldata);
                if (|e.cwe)  cmp1(e.req, "csr_data", csr_data_o, e.cdata);
            end
        end
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cmp1("R1", "redirect in reset", XLEN'(redirect_o), '0);
        cmp1("R1", "trap in reset", XLEN'(trap_o), '0);
        cmp1("R1", "link_we in reset", XLEN'(link_we_o), '0);
        cmp1("R1", "csr_we in reset", XLEN'(csr_we_o), '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        // R2 R5: legal direct jump, full-width instruction
        issue("R2", 1, 2'd1, 0, 0, 0, 32'h100, 32'h20, 32'h0, 2'b00, '0);
        idle("R9");
        // R4: direct jump with bit 1 set, compressed disabled
        issue("R4", 1, 2'd1, 0, 0, 0, 32'h100, 32'h22, 32'h0, 2'b00, '0);
        // R6 R5: same destination with compressed enabled, 16-bit instruction
        issue("R6", 1, 2'd1, 0, 1, 1, 32'h100, 32'h22, 32'h0, 2'b00, '0);
        // R3: indirect jump with odd sum, bit 0 dropped, legal
        issue("R3", 1, 2'd2, 0, 0, 0, 32'h400, 32'h4, 32'h1001, 2'b00, '0);
        // R3 R4: odd sum clears to 0x1002, traps
        issue("R3", 1, 2'd2, 0, 0, 0, 32'h400, 32'h0, 32'h1003, 2'b00, '0);
        // R5: indirect jump from a compressed instruction
        issue("R5", 1, 2'd2, 0, 1, 1, 32'h2000, 32'h8, 32'h3000, 2'b00, '0);
        // R7: taken branch, legal, no link write
        issue("R7", 1, 2'd3, 1, 0, 0, 32'h200, 32'h10, 32'h0, 2'b00, '0);
        // R4: taken branch to bit-1 destination
        issue("R4", 1, 2'd3, 1, 0, 0, 32'h200, 32'h12, 32'h0, 2'b00, '0);
        // R7: not-taken branch with misaligned would-be destination
        issue("R7", 1, 2'd3, 0, 0, 0, 32'h200, 32'h12, 32'h0, 2'b00, '0);
        // R7: no-op class
        issue("R7", 1, 2'd0, 1, 0, 0, 32'h200, 32'h12, 32'h0, 2'b00, '0);
        // R8: exception-return write, compressed disabled
        issue("R8", 0, 2'd0, 0, 0, 0, '0, '0, '0, 2'b01, 32'hFFFF_FFFF);
        // R8: debug-return write, compressed disabled
        issue("R8", 0, 2'd0, 0, 0, 0, '0, '0, '0, 2'b10, 32'h8000_0007);
        // R8: compressed enabled keeps bit 1
        issue("R8", 0, 2'd0, 0, 1, 0, '0, '0, '0, 2'b01, 32'hFFFF_FFFF);
        // R9: valid dropped after an operation
        issue("R9", 1, 2'd1, 0, 0, 0, 32'h0, 32'h40, 32'h0, 2'b00, '0);
        issue("R9", 0, 2'd1, 0, 0, 0, 32'h0, 32'h40, 32'h0, 2'b00, '0);
        // R9: negative offset with wrap, then trap then legal back to back
        issue("R2", 1, 2'd3, 1, 0, 0, 32'h10, 32'hFFFF_FFF0, 32'h0, 2'b00, '0);
        issue("R4", 1, 2'd1, 0, 0, 0, 32'h10, 32'hFFFF_FFF2, 32'h0, 2'b00, '0);
        issue("R2", 1, 2'd1, 0, 0, 0, 32'h10, 32'h8, 32'h0, 2'b00, '0);
        idle("R9");
        idle("R9");
        while (sb.size() > 0) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule